// File: doc/BRIEF.md
# Low-Power Real-Time Counter with Seconds Alarm

This block keeps time in a slow 32.768 kHz domain with a 47-bit free-running counter. The upper 32 bits are whole seconds and the lower 15 bits are a fraction of a second. Software reaches it through a 32-bit register bus on a fast clock. Through that bus it can load the counter while the counter is stopped, start and stop counting, and program a seconds alarm. It can also enable the alarm and a wakeup interrupt, and observe or clear a sticky alarm flag.

Every bus write that must reach the slow domain is gathered into a payload. The payload crosses through a toggle request with two-flop synchronisers and is acknowledged by a toggle back. Counter, flag and enable state return to the bus domain through synchronisers. The counter is read through a copy that is refreshed only when two successive samples agree. A plain 32-bit word models the setup register of a supply-glitch detector.

Top module: `rtc_lp`

## Requirements
- R1: After reset, every register reads 0 (control 0x38, status 0x4C, counter words 0x50/0x54, alarm 0x58, glitch word 0x64), and `irq` is 0.
- R2: While enabled, the counter advances by one on each slow-clock edge. Word 0x50 bits [14:0] hold counter bits [46:32], and word 0x54 holds bits [31:0]. Seconds are the counter shifted right by 15.
- R3: A write to 0x50 or 0x54 loads the counter only if counting is disabled when the write reaches the slow domain. Otherwise it has no effect on the count.
- R4: Control bit 0 enables counting, bit 1 enables the alarm and bit 3 enables the wakeup interrupt. Bit 0 reads back 0 right after it is written to 1 and reads 1 only once the write has reached the slow domain, which takes about three slow cycles.
- R5: Status bit 0 is set when the counter's seconds equal the value at 0x58 while control bit 1 is 1. With bit 1 at 0 it stays clear.
- R6: Status bit 0 is sticky. Writing 1 to it clears it, and writing 0 leaves it set.
- R7: `irq` is status bit 0 AND (control bit 1 OR control bit 3).
- R8: Word 0x64 holds any 32-bit value written to it, including the setup word 0x41736166.
- R9: The counter wraps from 2^47-1 to 0.
- R10: Word 0x58 reads back the 32-bit seconds value last written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| lp_clk | input | 1 | Slow 32.768 kHz counter clock |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| wr_en | input | 1 | Register write strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq | output | 1 | Alarm / wakeup interrupt, bus-clock domain |

## Verification
The assertions take for granted that software does not rewrite the alarm value while the alarm is enabled. The slow domain compares against its captured copy, and a rewrite would move the match point mid-second. They also assume `lp_clk` is several times slower than `clk`, so the counter copy settles between slow edges. The stimulus runs the slow clock about eight times slower than the bus clock. It stops counting before it loads the counter, and it waits a fixed number of slow cycles after each control write before it reads back any result of the crossing.

// File: rtl/rtc_lp.sv
module rtc_lp #(
  parameter int CNT_W  = 47,
  parameter int FRAC_W = 15,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              lp_clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              irq
);
  localparam int SEC_W = CNT_W - FRAC_W;
  localparam int HI_W  = CNT_W - 32;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'('h38);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'('h4C);
  localparam logic [ADDR_W-1:0] A_CHI  = ADDR_W'('h50);
  localparam logic [ADDR_W-1:0] A_CLO  = ADDR_W'('h54);
  localparam logic [ADDR_W-1:0] A_ALM  = ADDR_W'('h58);
  localparam logic [ADDR_W-1:0] A_GLT  = ADDR_W'('h64);

  // bus-side shadows and launched payload
  logic             en_sh, alm_sh, wke_sh, ld_sh, clr_sh, pend;
  logic [CNT_W-1:0] cnt_sh, pl_cnt;
  logic [SEC_W-1:0] alarm_sh, pl_alarm;
  logic [31:0]      glitch;
  logic             pl_en, pl_alm, pl_wke, pl_ld, pl_clr;
  logic             req_tgl, a1, a2;
  logic [2:0]       b1, b2;
  logic [CNT_W-1:0] s1, s2, cnt_copy;

  // slow-domain state
  logic             rq1, rq2, ack_tgl;
  logic             en_s, alm_s, wke_s, flag;
  logic [SEC_W-1:0] alarm_s;
  logic [CNT_W-1:0] cnt;

  wire idle = (req_tgl == a2);
  wire upd  = (rq2 != ack_tgl);
  wire hit  = alm_s && (cnt[CNT_W-1:FRAC_W] == alarm_s);
  wire irq_s = flag & (alm_s | wke_s);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {en_sh, alm_sh, wke_sh, ld_sh, clr_sh, pend} <= '0;
      cnt_sh <= '0; alarm_sh <= '0; glitch <= '0;
      {pl_en, pl_alm, pl_wke, pl_ld, pl_clr} <= '0;
      pl_cnt <= '0; pl_alarm <= '0; req_tgl <= 1'b0;
    end else begin
      if (idle && pend) begin
        {pl_en, pl_alm, pl_wke} <= {en_sh, alm_sh, wke_sh};
        pl_cnt <= cnt_sh; pl_alarm <= alarm_sh;
        pl_ld <= ld_sh; pl_clr <= clr_sh;
        ld_sh <= 1'b0; clr_sh <= 1'b0; pend <= 1'b0;
        req_tgl <= ~req_tgl;
      end
      if (wr_en) begin
        case (addr)
          A_CTRL: begin {wke_sh, alm_sh, en_sh} <= {wdata[3], wdata[1], wdata[0]}; pend <= 1'b1; end
          A_STAT: if (wdata[0]) begin clr_sh <= 1'b1; pend <= 1'b1; end
          A_CHI:  begin cnt_sh[CNT_W-1:32] <= wdata[HI_W-1:0]; ld_sh <= 1'b1; pend <= 1'b1; end
          A_CLO:  begin cnt_sh[31:0] <= wdata; ld_sh <= 1'b1; pend <= 1'b1; end
          A_ALM:  begin alarm_sh <= wdata[SEC_W-1:0]; pend <= 1'b1; end
          A_GLT:  glitch <= wdata;
          default: ;
        endcase
      end
    end
  end

  // slow-domain return path and stable counter copy
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a1 <= 1'b0; a2 <= 1'b0; b1 <= '0; b2 <= '0;
      s1 <= '0; s2 <= '0; cnt_copy <= '0;
    end else begin
      a1 <= ack_tgl; a2 <= a1;
      b1 <= {irq_s, flag, en_s}; b2 <= b1;
      s1 <= cnt; s2 <= s1;
      if (s1 == s2) cnt_copy <= s2;
    end
  end

  always_ff @(posedge lp_clk or negedge rst_n) begin
    if (!rst_n) begin
      rq1 <= 1'b0; rq2 <= 1'b0; ack_tgl <= 1'b0;
      {en_s, alm_s, wke_s, flag} <= '0;
      alarm_s <= '0; cnt <= '0;
    end else begin
      rq1 <= req_tgl; rq2 <= rq1;
      if (upd) begin
        ack_tgl <= rq2;
        {en_s, alm_s, wke_s} <= {pl_en, pl_alm, pl_wke};
        alarm_s <= pl_alarm;
      end
      if (en_s) cnt <= cnt + 1'b1;
      else if (upd && pl_ld) cnt <= pl_cnt;
      flag <= hit | (flag & ~(upd & pl_clr));
    end
  end

  assign irq = b2[2];

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL: rdata = {28'd0, wke_sh, 1'b0, alm_sh, b2[0]};
      A_STAT: rdata = {31'd0, b2[1]};
      A_CHI:  rdata[HI_W-1:0] = cnt_copy[CNT_W-1:32];
      A_CLO:  rdata = cnt_copy[31:0];
      A_ALM:  rdata[SEC_W-1:0] = alarm_sh;
      A_GLT:  rdata = glitch;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/rtc_lp_chk.sv
module rtc_lp_chk #(
  parameter int CNT_W  = 47,
  parameter int FRAC_W = 15
) (
  input logic             clk,
  input logic             lp_clk,
  input logic             rst_n,
  input logic             req_tgl,
  input logic             a2,
  input logic             upd,
  input logic             pl_ld,
  input logic             pl_clr,
  input logic             en_s,
  input logic             alm_s,
  input logic             flag,
  input logic [CNT_W-FRAC_W-1:0] alarm_s,
  input logic [CNT_W-1:0] cnt,
  input logic             irq,
  input logic [2:0]       b2
);
  p_count_r2: assert property (@(posedge lp_clk) disable iff (!rst_n)
    en_s |=> cnt == $past(cnt) + 1'b1);

  p_hold_r3: assert property (@(posedge lp_clk) disable iff (!rst_n)
    (!en_s && !(upd && pl_ld)) |=> $stable(cnt));

  p_launch_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_tgl != $past(req_tgl)) |-> ($past(req_tgl) == $past(a2)));

  p_alarm_set_r5: assert property (@(posedge lp_clk) disable iff (!rst_n)
    (alm_s && cnt[CNT_W-1:FRAC_W] == alarm_s) |=> flag);

  p_sticky_r6: assert property (@(posedge lp_clk) disable iff (!rst_n)
    (flag && !(upd && pl_clr)) |=> flag);

  p_irq_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> b2[1]);
endmodule

bind rtc_lp rtc_lp_chk #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_chk (
  .clk(clk), .lp_clk(lp_clk), .rst_n(rst_n), .req_tgl(req_tgl), .a2(a2),
  .upd(upd), .pl_ld(pl_ld), .pl_clr(pl_clr), .en_s(en_s), .alm_s(alm_s),
  .flag(flag), .alarm_s(alarm_s), .cnt(cnt), .irq(irq), .b2(b2)
);

// File: tb/tb_rtc_lp.sv
`timescale 1ns/1ps
module tb_rtc_lp;
  logic clk = 0, lp_clk = 0, rst_n = 0;
  logic wr_en = 0;
  logic [7:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;
  int n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;
  always #21 lp_clk = ~lp_clk;

  rtc_lp dut (.clk(clk), .lp_clk(lp_clk), .rst_n(rst_n), .wr_en(wr_en),
              .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  function automatic logic [31:0] hi_of(logic [46:0] v); return {17'd0, v[46:32]}; endfunction
  function automatic logic [31:0] lo_of(logic [46:0] v); return v[31:0]; endfunction
  function automatic logic [31:0] secs_of(logic [31:0] h, logic [31:0] l);
    logic [46:0] v = {h[14:0], l};
    return v[46:15];
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic settle();
    repeat (12) @(posedge lp_clk);
    repeat (4) @(posedge clk);
  endtask

  task automatic load(logic [46:0] v);
    wr(8'h54, lo_of(v)); wr(8'h50, hi_of(v)); settle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, h, l;
    logic [46:0] v;
    repeat (5) @(posedge clk);
    rst_n = 1;
    repeat (3) @(posedge clk);
    // R1 reset state
    rd(8'h38, d); chk("R1 ctrl", d, 0);
    rd(8'h4C, d); chk("R1 stat", d, 0);
    rd(8'h50, d); chk("R1 hi", d, 0);
    rd(8'h54, d); chk("R1 lo", d, 0);
    rd(8'h58, d); chk("R1 alarm", d, 0);
    rd(8'h64, d); chk("R1 glitch", d, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    // R4 enable readback lag
    wr(8'h38, 32'h1);
    rd(8'h38, d); chk("R4 lag", d, 0);
    settle();
    rd(8'h38, d); chk("R4 synced", d, 1);
    wr(8'h38, 32'h0); settle();
    rd(8'h38, d); chk("R4 off", d, 0);
    // R8 setup word
    wr(8'h64, 32'h41736166);
    rd(8'h64, d); chk("R8 init word", d, 32'h41736166);
    // random loads, alarm and glitch words (R2, R10, R8)
    void'($urandom(32'h5eed));
    for (int i = 0; i < 6; i++) begin
      v = {$urandom, $urandom};
      load(v);
      rd(8'h50, h); chk("R2 hi word", h, hi_of(v));
      rd(8'h54, l); chk("R2 lo word", l, lo_of(v));
      d = $urandom; wr(8'h58, d);
      rd(8'h58, h); chk("R10 alarm readback", h, d);
      d = $urandom; wr(8'h64, d);
      rd(8'h64, h); chk("R8 glitch readback", h, d);
    end
    // R2 counting across a second boundary
    load({32'h12345678, 15'h7FF0});
    wr(8'h38, 32'h1); settle();
    repeat (20) @(posedge lp_clk);
    rd(8'h50, h); rd(8'h54, l);
    chk("R2 seconds", secs_of(h, l), 32'h12345679);
    // R3 counter write ignored while running
    wr(8'h54, 32'h0); wr(8'h50, 32'h0); settle();
    rd(8'h50, h); rd(8'h54, l);
    chk("R3 ignored", secs_of(h, l), 32'h12345679);
    // R5 alarm disabled: no flag
    wr(8'h38, 32'h0); settle();
    load({32'h00000100, 15'h7FF0});
    wr(8'h58, 32'h101);
    wr(8'h38, 32'h1); settle();
    repeat (20) @(posedge lp_clk);
    rd(8'h4C, d); chk("R5 no flag", d, 0);
    chk("R7 irq low", {31'd0, irq}, 0);
    // R5 alarm enabled
    wr(8'h38, 32'h0); settle();
    load({32'h00000100, 15'h7FF0});
    wr(8'h38, 32'h3); settle();
    repeat (20) @(posedge lp_clk);
    rd(8'h4C, d); chk("R5 flag", d, 1);
    chk("R7 irq alarm", {31'd0, irq}, 1);
    // R7 wakeup enable alone
    wr(8'h38, 32'h9); settle();
    rd(8'h38, d); chk("R4 bits", d, 32'h9);
    chk("R7 irq wakeup", {31'd0, irq}, 1);
    wr(8'h38, 32'h1); settle();
    chk("R7 irq masked", {31'd0, irq}, 0);
    // R6 sticky / W1C
    rd(8'h4C, d); chk("R6 sticky", d, 1);
    wr(8'h4C, 32'h0); settle();
    rd(8'h4C, d); chk("R6 write0", d, 1);
    wr(8'h4C, 32'h1); settle();
    rd(8'h4C, d); chk("R6 cleared", d, 0);
    // R9 wrap
    wr(8'h38, 32'h0); settle();
    load(47'h7FFF_FFFF_FFF0);
    wr(8'h38, 32'h1); settle();
    repeat (10) @(posedge lp_clk);
    wr(8'h38, 32'h0); settle();
    rd(8'h50, h); rd(8'h54, l);
    chk("R9 hi wrapped", h, 0);
    chk("R9 lo small", {31'd0, (l != 0 && l < 200)}, 1);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule